// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives a host processor indirect access to two internal configuration tables through a small memory-mapped register space. One table holds 32 classification scheme entries of 23 words each. The other holds 64 per-port entries of two words each: a scheme-partition word and a classification-plan-partition word. The host never addresses a table word directly. It stages data in a shared 63-word window. It then writes a single command word that names the table, the entry, the direction and the words involved.

A command with its start bit set runs a sequencer that moves one word per clock between the window and the chosen entry. While the move runs, the start bit reads back as 1. When it clears, the host reads the error bit to learn whether the command was rejected. A rejected command moves nothing and occupies the engine for a single cycle. The tables only store values; the block gives them no meaning. By convention, scheme i is bit (31 − i) of a partition word.

Top module: `tbl_xfer_engine`

## Requirements
- R1: After reset, every window word, every scheme word and every port word is 0, and the command register reads 0.
- R2: Byte address 0x100 + 4k (k = 0..62) is window word k, and a host write to it reads back unchanged. Addresses below 0x100 read 0, and writes to them are ignored. Address bits 1:0 are ignored.
- R3: The command register is at 0x1FC. A write with bit 31 = 1 starts a transfer, and bit 31 then reads 1 until the transfer ends. Readback holds bit 30 (1 = table to window, 0 = window to table), error bit 29, target bits 25:24, scheme field 23:16, word selects 15:14 and port field 7:0. All other bits read 0. While bit 31 reads 1, bit 29 reads 0.
- R4: Bit 31 stays 1 for exactly 23 cycles for a scheme command, 2 cycles for a port command and 1 cycle for a rejected command.
- R5: A scheme write (target 00, bit 30 = 0) copies window words 0..22 into scheme entry bits 23:16. Entry word 16 is the packet counter, and it is written only when bit 15 is 1.
- R6: A scheme read (target 00, bit 30 = 1) copies all 23 entry words, including the counter, into window words 0..22. Window words 23..62 are left unchanged.
- R7: A port command (target 10) addresses port bits 7:0. Bit 15 moves the scheme-partition word to or from window word 0. Bit 14 moves the plan-partition word to or from window word 1. A word that is not selected is left unchanged in both the table and the window.
- R8: A command is rejected when the target is 01 or 11, the scheme number is 32 or more, the port number is 64 or more, or a port command sets neither bit 15 nor bit 14. A rejected command sets bit 29 and changes no table or window word. The next accepted command clears bit 29.
- R9: While bit 31 reads 1, host writes to the window and to the command register are ignored.
- R10: A write to the command register with bit 31 = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 9 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from bus_addr |

## Verification
Some properties are checked on every cycle. An accepted command raises the busy bit on the next cycle. No busy run lasts longer than a scheme transfer. A rejected command writes neither a table nor the window, and it raises the error bit exactly as the busy bit drops. The error bit is never visible while busy. Other behaviour can only be shown by the bench's scenarios, which read back through the window what a write left in the tables. These are the exact word mapping, the counter-word skip, preservation of unselected words, the exact busy length of each command type, and the host writes that are ignored.

// File: rtl/txe_pkg.sv
package txe_pkg;

  typedef enum logic [1:0] {
    TGT_SCHEME = 2'b00,
    TGT_PLAN   = 2'b01,
    TGT_PORT   = 2'b10,
    TGT_DUAL   = 2'b11
  } tgt_e;

  // Command bits kept for readback: direction, target, scheme field,
  // word selects, port field.
  localparam logic [31:0] CMD_KEEP = 32'h43FF_C0FF;

  // True when a command can not be carried out.
  function automatic logic cmd_bad(input logic [31:0] c,
                                   input int unsigned ns,
                                   input int unsigned np);
    logic r;
    case (c[25:24])
      TGT_SCHEME: r = ({24'd0, c[23:16]} >= ns);
      TGT_PORT:   r = ({24'd0, c[7:0]} >= np) || (c[15:14] == 2'b00);
      default:    r = 1'b1;
    endcase
    return r;
  endfunction

  // Index of the final word step of an accepted command.
  function automatic int unsigned last_word(input logic [31:0] c,
                                            input int unsigned sw);
    return (c[25:24] == TGT_SCHEME) ? sw - 1 : 1;
  endfunction

  // Whether word step idx actually moves data.
  function automatic logic word_on(input logic [31:0] c,
                                   input int unsigned idx,
                                   input int unsigned cw);
    if (c[25:24] == TGT_SCHEME)
      return c[30] || c[15] || (idx != cw);
    return (idx == 0) ? c[15] : c[14];
  endfunction

endpackage

// File: rtl/txe_window.sv
module txe_window #(
  parameter int unsigned WN  = 63,
  parameter int unsigned IW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [31:0]   host_d,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_idx,
  input  logic [31:0]   ld_d,
  input  logic [IW-1:0] ra_idx,
  output logic [31:0]   ra_d,
  input  logic [IW-1:0] rb_idx,
  output logic [31:0]   rb_d
);

  logic [31:0] word_q [WN];

  for (genvar i = 0; i < WN; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[i] <= '0;
      else if (ld_we && (ld_idx == IW'(i)))
        word_q[i] <= ld_d;
      else if (host_we && (host_idx == IW'(i)))
        word_q[i] <= host_d;
    end
  end

  assign ra_d = ({{(32-IW){1'b0}}, ra_idx} < WN) ? word_q[ra_idx] : '0;
  assign rb_d = ({{(32-IW){1'b0}}, rb_idx} < WN) ? word_q[rb_idx] : '0;

endmodule

// File: rtl/txe_tables.sv
module txe_tables #(
  parameter int unsigned NS  = 32,
  parameter int unsigned NP  = 64,
  parameter int unsigned SW  = 23,
  parameter int unsigned SIW = 5,
  parameter int unsigned PIW = 6,
  parameter int unsigned CIW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           is_port,
  input  logic [SIW-1:0] sch_idx,
  input  logic [PIW-1:0] prt_idx,
  input  logic [CIW-1:0] word,
  input  logic [31:0]    wd,
  output logic [31:0]    rd
);

  logic [31:0] sch_mem [NS][SW];
  logic [31:0] prt_mem [NP][2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NS; e++)
        for (int w = 0; w < SW; w++)
          sch_mem[e][w] <= '0;
      for (int e = 0; e < NP; e++) begin
        prt_mem[e][0] <= '0;
        prt_mem[e][1] <= '0;
      end
    end else if (we) begin
      if (is_port)
        prt_mem[prt_idx][word[0]] <= wd;
      else if ({{(32-CIW){1'b0}}, word} < SW)
        sch_mem[sch_idx][word] <= wd;
    end
  end

  always_comb begin
    if (is_port)
      rd = prt_mem[prt_idx][word[0]];
    else if ({{(32-CIW){1'b0}}, word} < SW)
      rd = sch_mem[sch_idx][word];
    else
      rd = '0;
  end

endmodule

// File: rtl/txe_seq.sv
module txe_seq
  import txe_pkg::*;
#(
  parameter int unsigned NS  = 32,
  parameter int unsigned NP  = 64,
  parameter int unsigned SW  = 23,
  parameter int unsigned CW  = 16,
  parameter int unsigned CIW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [31:0]    cmd_in,
  output logic           go,
  output logic           err,
  output logic           bad,
  output logic [31:0]    cmd_q,
  output logic [CIW-1:0] cnt,
  output logic           mv_tbl,
  output logic           mv_win
);

  logic step_on;
  logic at_last;

  assign step_on = word_on(cmd_q, 32'(cnt), CW);
  assign at_last = (32'(cnt) == last_word(cmd_q, SW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go    <= 1'b0;
      err   <= 1'b0;
      bad   <= 1'b0;
      cmd_q <= '0;
      cnt   <= '0;
    end else if (start) begin
      go    <= 1'b1;
      err   <= 1'b0;
      bad   <= cmd_bad(cmd_in, NS, NP);
      cmd_q <= cmd_in & CMD_KEEP;
      cnt   <= '0;
    end else if (go) begin
      if (bad) begin
        go  <= 1'b0;
        err <= 1'b1;
      end else if (at_last) begin
        go  <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mv_tbl = go && !bad && !cmd_q[30] && step_on;
  assign mv_win = go && !bad &&  cmd_q[30] && step_on;

endmodule

// File: rtl/tbl_xfer_engine.sv
module tbl_xfer_engine
  import txe_pkg::*;
#(
  parameter int unsigned NUM_SCHEMES  = 32,
  parameter int unsigned NUM_PORTS    = 64,
  parameter int unsigned SCHEME_WORDS = 23,
  parameter int unsigned COUNTER_WORD = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [8:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int unsigned WIN_WORDS = 63;
  localparam int unsigned WIW       = 6;
  localparam int unsigned SIW       = (NUM_SCHEMES > 1) ? $clog2(NUM_SCHEMES) : 1;
  localparam int unsigned PIW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned CIW       = $clog2(SCHEME_WORDS);

  // Decoded host events.
  logic [WIW-1:0] host_idx;
  logic           sel_hi;
  logic           sel_cmd;
  logic           sel_win;
  logic           win_host_we;
  logic           start;

  assign host_idx    = bus_addr[7:2];
  assign sel_hi      = bus_addr[8];
  assign sel_cmd     = sel_hi && (host_idx == WIW'(WIN_WORDS));
  assign sel_win     = sel_hi && !sel_cmd;

  // Sequencer outputs.
  logic           go;
  logic           err;
  logic           bad;
  logic [31:0]    cmd_q;
  logic [CIW-1:0] cnt;
  logic           mv_tbl;
  logic           mv_win;

  assign win_host_we = bus_wr && sel_win && !go;
  assign start       = bus_wr && sel_cmd && bus_wdata[31] && !go;

  txe_seq #(
    .NS (NUM_SCHEMES), .NP (NUM_PORTS), .SW (SCHEME_WORDS),
    .CW (COUNTER_WORD), .CIW (CIW)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cmd_in (bus_wdata),
    .go     (go),
    .err    (err),
    .bad    (bad),
    .cmd_q  (cmd_q),
    .cnt    (cnt),
    .mv_tbl (mv_tbl),
    .mv_win (mv_win)
  );

  logic [31:0]    win_rd;
  logic [31:0]    win_src;
  logic [31:0]    tbl_rd;
  logic [WIW-1:0] step_idx;

  assign step_idx = WIW'(cnt);

  txe_window #(.WN (WIN_WORDS), .IW (WIW)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_we  (win_host_we),
    .host_idx (host_idx),
    .host_d   (bus_wdata),
    .ld_we    (mv_win),
    .ld_idx   (step_idx),
    .ld_d     (tbl_rd),
    .ra_idx   (host_idx),
    .ra_d     (win_rd),
    .rb_idx   (step_idx),
    .rb_d     (win_src)
  );

  txe_tables #(
    .NS (NUM_SCHEMES), .NP (NUM_PORTS), .SW (SCHEME_WORDS),
    .SIW (SIW), .PIW (PIW), .CIW (CIW)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mv_tbl),
    .is_port (cmd_q[25]),
    .sch_idx (cmd_q[16 +: SIW]),
    .prt_idx (cmd_q[0 +: PIW]),
    .word    (cnt),
    .wd      (win_src),
    .rd      (tbl_rd)
  );

  logic [31:0] cmd_view;
  assign cmd_view = {go, cmd_q[30], err, cmd_q[28:0]};

  always_comb begin
    if (sel_cmd)      bus_rdata = cmd_view;
    else if (sel_win) bus_rdata = win_rd;
    else              bus_rdata = '0;
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], cmd_q[31], cmd_q[29:0]};

endmodule

// File: rtl/tbl_xfer_engine_chk.sv
module tbl_xfer_engine_chk #(
  parameter int unsigned SW = 23
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic go,
  input logic err,
  input logic bad,
  input logic mv_tbl,
  input logic mv_win
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run_q <= '0;
    else if (go)  run_q <= run_q + 8'd1;
    else          run_q <= '0;
  end

  a_r3_go_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> go);

  a_r3_err_hidden_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !err);

  a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ({24'd0, run_q} < SW));

  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bad) |-> (!mv_tbl && !mv_win));

  a_r8_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bad) |=> (!go && err));

endmodule

bind tbl_xfer_engine tbl_xfer_engine_chk #(.SW (SCHEME_WORDS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .go     (go),
  .err    (err),
  .bad    (bad),
  .mv_tbl (mv_tbl),
  .mv_win (mv_win)
);

// File: tb/tbl_xfer_engine_test.sv
`timescale 1ns/1ps
module tbl_xfer_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tbl_xfer_engine uut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
  );

  // Bench model of storage, built from the requirements.
  logic [31:0] m_sch [32][23];
  logic [31:0] m_prt [64][2];
  logic [31:0] m_win [63];

  localparam int NV = 16;
  localparam logic [31:0] V_CMD [NV] = '{
    32'h8005_8000, 32'h801F_0000, 32'hC005_0000, 32'hC01F_0000,
    32'hC020_0000, 32'h8200_C03F, 32'h8200_4000, 32'hC200_C03F,
    32'hC200_8000, 32'hC200_4000, 32'hC200_C040, 32'h8100_0000,
    32'h8300_0000, 32'h8200_0003, 32'hC007_0000, 32'h80FF_8000 };
  localparam int V_CYC [NV] = '{23, 23, 23, 23, 1, 2, 2, 2, 2, 2, 1, 1, 1, 1, 23, 1};
  localparam bit V_ERR [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic fill_window(input int seed);
    for (int k = 0; k < 63; k++) begin
      logic [31:0] p;
      p = {8'(seed), 8'(k), 8'h5A, 8'(k * 3 + seed)};
      bus_write(9'h100 + 9'(k * 4), p);
      m_win[k] = p;
    end
  endtask

  task automatic compare_window(input string req);
    logic [31:0] r;
    int miss;
    miss = -1;
    for (int k = 0; k < 63; k++) begin
      bus_read(9'h100 + 9'(k * 4), r);
      if (miss < 0 && r !== m_win[k]) miss = k;
    end
    total++;
    if (miss >= 0) begin
      bus_read(9'h100 + 9'(miss * 4), r);
      bad++;
      $display("FAIL %s window word %0d actual=%h expected=%h", req, miss, r, m_win[miss]);
    end
  endtask

  // Issue a command and count the cycles the start bit reads 1.
  task automatic run_cmd(input logic [31:0] cmd, output int cyc, output logic [31:0] fin);
    bus_write(9'h1FC, cmd);
    cyc = 0;
    bus_read(9'h1FC, fin);
    while (fin[31] && cyc < 300) begin
      cyc++;
      @(negedge clk);
      bus_read(9'h1FC, fin);
    end
  endtask

  function automatic bit model_bad(input logic [31:0] c);
    if (c[25:24] == 2'b00) return c[23:16] >= 8'd32;
    if (c[25:24] == 2'b10) return (c[7:0] >= 8'd64) || (c[15:14] == 2'b00);
    return 1'b1;
  endfunction

  task automatic model_apply(input logic [31:0] c);
    int n;
    if (model_bad(c)) return;
    if (c[25:24] == 2'b00) begin
      n = int'(c[23:16]);
      for (int k = 0; k < 23; k++) begin
        if (c[30]) m_win[k] = m_sch[n][k];
        else if (k != 16 || c[15]) m_sch[n][k] = m_win[k];
      end
    end else begin
      n = int'(c[7:0]);
      for (int k = 0; k < 2; k++) begin
        if ((k == 0) ? c[15] : c[14]) begin
          if (c[30]) m_win[k] = m_prt[n][k];
          else m_prt[n][k] = m_win[k];
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int cyc;
    string tag;

    for (int e = 0; e < 32; e++) for (int w = 0; w < 23; w++) m_sch[e][w] = '0;
    for (int e = 0; e < 64; e++) begin m_prt[e][0] = '0; m_prt[e][1] = '0; end
    for (int k = 0; k < 63; k++) m_win[k] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of command register and window.
    bus_read(9'h1FC, r);
    check("R1 command reg after reset", r, 32'h0);
    compare_window("R1 window after reset");

    // R2: low addresses ignore writes and read 0; window words read back.
    bus_write(9'h0F0, 32'hDEAD_BEEF);
    bus_read(9'h0F0, r);
    check("R2 low address", r, 32'h0);
    bus_write(9'h107, 32'h1234_5678);
    m_win[1] = 32'h1234_5678;
    bus_read(9'h104, r);
    check("R2 window readback", r, 32'h1234_5678);

    // R10: command write without start bit is ignored.
    bus_write(9'h1FC, 32'h4005_8000);
    @(negedge clk);
    bus_read(9'h1FC, r);
    check("R10 no start", r, 32'h0);

    // Vector table.
    for (int v = 0; v < NV; v++) begin
      fill_window(v + 1);
      run_cmd(V_CMD[v], cyc, r);
      if (V_ERR[v])                  tag = "R8";
      else if (V_CMD[v][25:24] != 0) tag = "R7";
      else if (V_CMD[v][30])         tag = "R6";
      else                           tag = "R5";
      check($sformatf("R4 busy length vec %0d", v), 32'(cyc), 32'(V_CYC[v]));
      check($sformatf("R8 error bit vec %0d", v), {31'd0, r[29]}, {31'd0, V_ERR[v]});
      check($sformatf("R3 readback vec %0d", v), r,
            (V_CMD[v] & 32'h43FF_C0FF) | (V_ERR[v] ? 32'h2000_0000 : 32'h0));
      model_apply(V_CMD[v]);
      compare_window($sformatf("%s window vec %0d (R1 for vec 14)", tag, v));
    end

    // R9: writes during a transfer are ignored.
    fill_window(40);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'h1FC; bus_wdata = 32'h8009_8000;
    @(negedge clk);
    bus_addr = 9'h10C; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_addr = 9'h1FC; bus_wdata = 32'hC200_C001;
    @(negedge clk);
    bus_wr = 1'b0;
    cyc = 0;
    bus_read(9'h1FC, r);
    while (r[31] && cyc < 300) begin
      cyc++;
      @(negedge clk);
      bus_read(9'h1FC, r);
    end
    check("R9 command reg kept", r, 32'h0009_8000);
    model_apply(32'h8009_8000);
    compare_window("R9 window kept");
    fill_window(41);
    run_cmd(32'hC009_0000, cyc, r);
    model_apply(32'hC009_0000);
    compare_window("R9 table took pre-busy window");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule